// File: doc/BRIEF.md
# Word-State Self-Invalidating Private Cache Controller

This block is the controller for one core's private first-level cache in a coherence scheme that relies on data-race freedom within each parallel phase. The controller keeps one address tag per 16-word line and tracks coherence separately for every 32-bit word. Each word is Invalid, Valid or Registered. A load to an Invalid word fetches that word from the shared second-level cache. A store takes ownership of the word by sending a registration to the shared level. No directory ever sends an invalidation into this cache.

Stale data is removed by the cache itself when software ends a phase. It supplies a mask of the regions written during that phase. Each line records a 5-bit region number when it is allocated. Each word has a touched bit that only loads set. The phase-end scan visits one line per cycle. It drops every Valid, untouched word whose region bit is set in the mask. It then clears all touched bits and pulses a done flag.

Core requests and L2 requests use valid/ready handshakes. A request may be withdrawn or changed only after it is accepted. The controller holds `l2_req_*` stable while `l2_req_ready` is low. It holds `core_rsp_*` stable until the core raises `core_rsp_ready`. Only one core request is in service at a time, and `core_req_ready` stays low until the response of the previous request has been taken. L2 responses carry no ready signal and are always accepted. Addresses are word addresses: bits [3:0] select the word, bits [5:4] select the line and the upper bits form the tag.

Top module: `selfinv_l1`

## Requirements
- R1: After reset, every word is Invalid, all touched bits are clear, `regs_busy` is 0, `core_req_ready` is 1, and `core_rsp_valid` and `l2_req_valid` are 0.
- R2: A load to an Invalid word sends one L2 request of kind 0 (read) for that word address. The word becomes Valid when a response of kind 0 (fill) arrives, and the load returns the fill data. A later load to that word hits and sends no request.
- R3: A store to an Invalid or Valid word writes the data and makes the word Registered. It sends one L2 request of kind 1 (registration) that carries the word address and the store data. A store to a word that is already Registered sends no request.
- R4: `regs_busy` is 1 while any registration has no acknowledgement yet, where an acknowledgement is an L2 response of kind 1. It returns to 0 when every registration has been acknowledged.
- R5: Only a load sets the touched bit of a word. Stores leave it unchanged.
- R6: At phase end, a Valid word becomes Invalid only when its line's region bit is set in `phase_mask` and its touched bit is clear. Words in regions outside the mask are unchanged.
- R7: Phase-end processing never changes a Registered word.
- R8: Phase-end processing clears all touched bits. A word that was touched in one phase and not touched in the next is therefore dropped at the end of the next phase.
- R9: After `phase_start`, the scan starts only when no registration is outstanding. No core request is accepted until the scan ends. The scan takes one cycle per line. `phase_done` is a one-cycle pulse, and it appears NUM_LINES+2 cycles after the `phase_start` cycle when nothing is outstanding.
- R10: The states of the words in one line are independent. An access to one word does not change the state of its neighbours.
- R11: An L2 request that is not yet accepted keeps its valid, kind, address and data stable. A core response keeps its valid and data stable until it is taken.
- R12: An access whose tag differs from the tag held at its index reallocates the line. All words of the old line are lost, and the new line starts with every word Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req_valid | input | 1 | Core request valid |
| core_req_ready | output | 1 | Controller can accept a core request |
| core_req_write | input | 1 | 1 = store, 0 = load |
| core_req_waddr | input | WADDR_W | Word address of the request |
| core_req_wdata | input | DATA_W | Store data |
| core_req_region | input | REG_W | Region number recorded when the line is allocated |
| core_rsp_valid | output | 1 | Response valid |
| core_rsp_ready | input | 1 | Core takes the response |
| core_rsp_rdata | output | DATA_W | Load data (0 for stores) |
| l2_req_valid | output | 1 | L2 request valid |
| l2_req_ready | input | 1 | L2 accepts the request |
| l2_req_kind | output | 1 | 0 = read, 1 = registration |
| l2_req_waddr | output | WADDR_W | Word address of the L2 request |
| l2_req_wdata | output | DATA_W | Store data sent with a registration |
| l2_rsp_valid | input | 1 | L2 response valid |
| l2_rsp_kind | input | 1 | 0 = fill, 1 = registration acknowledgement |
| l2_rsp_rdata | input | DATA_W | Fill data |
| phase_start | input | 1 | One-cycle pulse that requests the phase-end scan |
| phase_mask | input | 2**REG_W | Regions written during the phase, captured with `phase_start` |
| phase_done | output | 1 | One-cycle pulse when the scan has finished |
| regs_busy | output | 1 | At least one registration is still unacknowledged |

## Verification
The bench checks that a scan leaves a touched Valid word alone in one phase and drops it in the next. A design that never cleared the touched bits would keep that word forever, and one that ignored them would drop it too early. It sets up Registered words and words in regions outside the mask, then looks for reads on the L2 port after the scan. A purge that is too broad shows up as extra reads, and one that is too narrow shows up as missing reads. Acknowledgements are held back to prove that the scan waits for them and that the core is kept out during that wait. An index conflict and a stalled L2 request port check line reallocation and the stability of held requests and responses.

// File: rtl/l1sc_pkg.sv
package l1sc_pkg;
  localparam logic [1:0] WS_INV = 2'b00;
  localparam logic [1:0] WS_VAL = 2'b01;
  localparam logic [1:0] WS_REG = 2'b10;

  localparam logic KIND_READ = 1'b0;
  localparam logic KIND_REGISTER = 1'b1;
  localparam logic KIND_FILL = 1'b0;
  localparam logic KIND_ACK = 1'b1;

  typedef enum logic [2:0] {
    C_IDLE,
    C_RDREQ,
    C_RDWAIT,
    C_REGREQ,
    C_RSP,
    C_SCAN
  } ctrl_state_e;
endpackage

// File: rtl/l1sc_addr_split.sv
module l1sc_addr_split #(
  parameter int WADDR_W = 14,
  parameter int WSEL_W  = 4,
  parameter int IDX_W   = 2,
  parameter int TAG_W   = 8
) (
  input  logic [WADDR_W-1:0] waddr,
  output logic [WSEL_W-1:0]  word_sel,
  output logic [IDX_W-1:0]   line_sel,
  output logic [TAG_W-1:0]   tag
);
  assign word_sel = waddr[WSEL_W-1:0];
  assign line_sel = waddr[WSEL_W+IDX_W-1:WSEL_W];
  assign tag      = waddr[WADDR_W-1:WSEL_W+IDX_W];
endmodule

// File: rtl/l1sc_line_purge.sv
module l1sc_line_purge
  import l1sc_pkg::*;
#(
  parameter int LINE_WORDS = 16,
  parameter int REG_W      = 5,
  localparam int MASK_W    = 1 << REG_W
) (
  input  logic [LINE_WORDS-1:0][1:0] st_in,
  input  logic [LINE_WORDS-1:0]      touched,
  input  logic [REG_W-1:0]           region,
  input  logic [MASK_W-1:0]          mask,
  output logic [LINE_WORDS-1:0][1:0] st_out
);
  logic region_hit;
  assign region_hit = mask[region];

  for (genvar g = 0; g < LINE_WORDS; g++) begin : g_word
    always_comb begin
      if (st_in[g] == WS_VAL && region_hit && !touched[g])
        st_out[g] = WS_INV;
      else
        st_out[g] = st_in[g];
    end
  end
endmodule

// File: rtl/l1sc_reg_tracker.sv
module l1sc_reg_tracker #(
  parameter int MAX_PEND = 8,
  localparam int CNT_W   = $clog2(MAX_PEND + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic busy,
  output logic full
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc && !dec) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (dec && !inc && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
  assign full = (cnt_q == CNT_W'(MAX_PEND));
endmodule

// File: rtl/selfinv_l1.sv
module selfinv_l1
  import l1sc_pkg::*;
#(
  parameter int WADDR_W    = 14,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 16,
  parameter int NUM_LINES  = 4,
  parameter int REG_W      = 5,
  parameter int MAX_PEND   = 8,
  localparam int MASK_W    = 1 << REG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               core_req_valid,
  output logic               core_req_ready,
  input  logic               core_req_write,
  input  logic [WADDR_W-1:0] core_req_waddr,
  input  logic [DATA_W-1:0]  core_req_wdata,
  input  logic [REG_W-1:0]   core_req_region,
  output logic               core_rsp_valid,
  input  logic               core_rsp_ready,
  output logic [DATA_W-1:0]  core_rsp_rdata,
  output logic               l2_req_valid,
  input  logic               l2_req_ready,
  output logic               l2_req_kind,
  output logic [WADDR_W-1:0] l2_req_waddr,
  output logic [DATA_W-1:0]  l2_req_wdata,
  input  logic               l2_rsp_valid,
  input  logic               l2_rsp_kind,
  input  logic [DATA_W-1:0]  l2_rsp_rdata,
  input  logic               phase_start,
  input  logic [MASK_W-1:0]  phase_mask,
  output logic               phase_done,
  output logic               regs_busy
);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = WADDR_W - WSEL_W - IDX_W;

  ctrl_state_e state_q;

  // Per-line storage: tag, valid, region, per-word state, touched and data
  logic [TAG_W-1:0]           tag_q    [NUM_LINES];
  logic                       lval_q   [NUM_LINES];
  logic [REG_W-1:0]           region_q [NUM_LINES];
  logic [LINE_WORDS-1:0][1:0] st_q     [NUM_LINES];
  logic [LINE_WORDS-1:0]      touch_q  [NUM_LINES];
  logic [DATA_W-1:0]          data_q   [NUM_LINES][LINE_WORDS];

  // Captured request
  logic [WSEL_W-1:0]  q_word;
  logic [IDX_W-1:0]   q_line;
  logic [WADDR_W-1:0] q_waddr;
  logic [DATA_W-1:0]  q_wdata;
  logic [DATA_W-1:0]  rsp_data_q;

  // Phase-end control
  logic               pend_q;
  logic [MASK_W-1:0]  mask_q;
  logic [IDX_W-1:0]   scan_idx_q;
  logic               done_q;

  // Lookup of the incoming request
  logic [WSEL_W-1:0]  in_word;
  logic [IDX_W-1:0]   in_line;
  logic [TAG_W-1:0]   in_tag;
  logic               hit_line;
  logic [1:0]         cur_state;
  logic               accept;
  logic               fill_in;

  l1sc_addr_split #(
    .WADDR_W(WADDR_W), .WSEL_W(WSEL_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_split (
    .waddr(core_req_waddr), .word_sel(in_word), .line_sel(in_line), .tag(in_tag)
  );

  assign hit_line  = lval_q[in_line] && (tag_q[in_line] == in_tag);
  assign cur_state = hit_line ? st_q[in_line][in_word] : WS_INV;
  assign core_req_ready = (state_q == C_IDLE) && !pend_q;
  assign accept    = core_req_ready && core_req_valid;
  assign fill_in   = (state_q == C_RDWAIT) && l2_rsp_valid && (l2_rsp_kind == KIND_FILL);

  // Registration bookkeeping
  logic reg_full;
  logic reg_inc;
  logic ack_in;

  assign ack_in  = l2_rsp_valid && (l2_rsp_kind == KIND_ACK);
  assign reg_inc = (state_q == C_REGREQ) && !reg_full && l2_req_ready;

  l1sc_reg_tracker #(.MAX_PEND(MAX_PEND)) u_regs (
    .clk(clk), .rst_n(rst_n), .inc(reg_inc), .dec(ack_in),
    .busy(regs_busy), .full(reg_full)
  );

  // Purge logic for the line under scan
  logic [LINE_WORDS-1:0][1:0] purged;

  l1sc_line_purge #(.LINE_WORDS(LINE_WORDS), .REG_W(REG_W)) u_purge (
    .st_in(st_q[scan_idx_q]), .touched(touch_q[scan_idx_q]),
    .region(region_q[scan_idx_q]), .mask(mask_q), .st_out(purged)
  );

  // Control and state arrays
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= C_IDLE;
      pend_q     <= 1'b0;
      mask_q     <= '0;
      scan_idx_q <= '0;
      done_q     <= 1'b0;
      q_word     <= '0;
      q_line     <= '0;
      q_waddr    <= '0;
      q_wdata    <= '0;
      rsp_data_q <= '0;
      for (int i = 0; i < NUM_LINES; i++) begin
        tag_q[i]    <= '0;
        lval_q[i]   <= 1'b0;
        region_q[i] <= '0;
        st_q[i]     <= '0;
        touch_q[i]  <= '0;
      end
    end else begin
      done_q <= 1'b0;
      case (state_q)
        C_IDLE: begin
          if (pend_q) begin
            if (!regs_busy) begin
              state_q    <= C_SCAN;
              scan_idx_q <= '0;
              pend_q     <= 1'b0;
            end
          end else if (core_req_valid) begin
            q_word  <= in_word;
            q_line  <= in_line;
            q_waddr <= core_req_waddr;
            q_wdata <= core_req_wdata;
            if (!hit_line) begin
              lval_q[in_line]   <= 1'b1;
              tag_q[in_line]    <= in_tag;
              region_q[in_line] <= core_req_region;
              st_q[in_line]     <= '0;
              touch_q[in_line]  <= '0;
            end
            if (core_req_write) begin
              st_q[in_line][in_word] <= WS_REG;
              rsp_data_q <= '0;
              state_q    <= (cur_state == WS_REG) ? C_RSP : C_REGREQ;
            end else if (cur_state == WS_INV) begin
              state_q <= C_RDREQ;
            end else begin
              touch_q[in_line][in_word] <= 1'b1;
              rsp_data_q <= data_q[in_line][in_word];
              state_q    <= C_RSP;
            end
          end
        end
        C_RDREQ: begin
          if (l2_req_ready) state_q <= C_RDWAIT;
        end
        C_RDWAIT: begin
          if (fill_in) begin
            st_q[q_line][q_word]    <= WS_VAL;
            touch_q[q_line][q_word] <= 1'b1;
            rsp_data_q <= l2_rsp_rdata;
            state_q    <= C_RSP;
          end
        end
        C_REGREQ: begin
          if (reg_inc) state_q <= C_RSP;
        end
        C_RSP: begin
          if (core_rsp_ready) state_q <= C_IDLE;
        end
        C_SCAN: begin
          st_q[scan_idx_q]    <= purged;
          touch_q[scan_idx_q] <= '0;
          if (scan_idx_q == IDX_W'(NUM_LINES - 1)) begin
            state_q <= C_IDLE;
            done_q  <= 1'b1;
          end else begin
            scan_idx_q <= scan_idx_q + 1'b1;
          end
        end
        default: state_q <= C_IDLE;
      endcase
      if (phase_start) begin
        pend_q <= 1'b1;
        mask_q <= phase_mask;
      end
    end
  end

  // Word data array (no reset: contents are qualified by word state)
  always_ff @(posedge clk) begin
    if (accept && core_req_write)
      data_q[in_line][in_word] <= core_req_wdata;
    if (fill_in)
      data_q[q_line][q_word] <= l2_rsp_rdata;
  end

  assign l2_req_valid   = (state_q == C_RDREQ) || ((state_q == C_REGREQ) && !reg_full);
  assign l2_req_kind    = (state_q == C_REGREQ) ? KIND_REGISTER : KIND_READ;
  assign l2_req_waddr   = q_waddr;
  assign l2_req_wdata   = q_wdata;
  assign core_rsp_valid = (state_q == C_RSP);
  assign core_rsp_rdata = rsp_data_q;
  assign phase_done     = done_q;
endmodule

// File: rtl/selfinv_l1_chk.sv
module selfinv_l1_chk #(
  parameter int WADDR_W = 14,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               core_req_ready,
  input logic               core_rsp_valid,
  input logic               core_rsp_ready,
  input logic [DATA_W-1:0]  core_rsp_rdata,
  input logic               l2_req_valid,
  input logic               l2_req_ready,
  input logic               l2_req_kind,
  input logic [WADDR_W-1:0] l2_req_waddr,
  input logic [DATA_W-1:0]  l2_req_wdata,
  input logic               phase_done,
  input logic               regs_busy
);
  assert_l2_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    l2_req_valid && !l2_req_ready |=> l2_req_valid && $stable(l2_req_kind)
      && $stable(l2_req_waddr) && $stable(l2_req_wdata));

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    core_rsp_valid && !core_rsp_ready |=> core_rsp_valid && $stable(core_rsp_rdata));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |=> !phase_done);

  assert_done_no_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |-> !regs_busy);

  assert_busy_from_register_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(regs_busy) |-> $past(l2_req_valid && l2_req_ready && l2_req_kind));

  assert_single_activity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_req_ready, l2_req_valid, core_rsp_valid}));
endmodule

bind selfinv_l1 selfinv_l1_chk #(.WADDR_W(WADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_req_ready(core_req_ready),
  .core_rsp_valid(core_rsp_valid), .core_rsp_ready(core_rsp_ready),
  .core_rsp_rdata(core_rsp_rdata), .l2_req_valid(l2_req_valid),
  .l2_req_ready(l2_req_ready), .l2_req_kind(l2_req_kind),
  .l2_req_waddr(l2_req_waddr), .l2_req_wdata(l2_req_wdata),
  .phase_done(phase_done), .regs_busy(regs_busy)
);

// File: tb/selfinv_l1_tb.sv
module selfinv_l1_tb;
  localparam int WADDR_W = 14;
  localparam int DATA_W  = 32;
  localparam int NUM_LINES = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_req_valid = 1'b0;
  logic core_req_ready;
  logic core_req_write = 1'b0;
  logic [WADDR_W-1:0] core_req_waddr = '0;
  logic [DATA_W-1:0] core_req_wdata = '0;
  logic [4:0] core_req_region = '0;
  logic core_rsp_valid;
  logic core_rsp_ready = 1'b0;
  logic [DATA_W-1:0] core_rsp_rdata;
  logic l2_req_valid;
  logic l2_req_ready = 1'b1;
  logic l2_req_kind;
  logic [WADDR_W-1:0] l2_req_waddr;
  logic [DATA_W-1:0] l2_req_wdata;
  logic l2_rsp_valid = 1'b0;
  logic l2_rsp_kind = 1'b0;
  logic [DATA_W-1:0] l2_rsp_rdata = '0;
  logic phase_start = 1'b0;
  logic [31:0] phase_mask = '0;
  logic phase_done;
  logic regs_busy;

  int errors = 0;
  int checks = 0;

  // L2 model state
  int n_reads = 0;
  int n_regs = 0;
  int ack_pend = 0;
  bit hold_acks = 1'b0;
  bit fill_pend = 1'b0;
  logic [WADDR_W-1:0] fill_addr = '0;
  logic last_kind = 1'b0;
  logic [WADDR_W-1:0] last_waddr = '0;
  logic [DATA_W-1:0] last_wdata = '0;

  always #4 clk = ~clk;

  selfinv_l1 u_dut (
    .clk(clk), .rst_n(rst_n),
    .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
    .core_req_write(core_req_write), .core_req_waddr(core_req_waddr),
    .core_req_wdata(core_req_wdata), .core_req_region(core_req_region),
    .core_rsp_valid(core_rsp_valid), .core_rsp_ready(core_rsp_ready),
    .core_rsp_rdata(core_rsp_rdata),
    .l2_req_valid(l2_req_valid), .l2_req_ready(l2_req_ready),
    .l2_req_kind(l2_req_kind), .l2_req_waddr(l2_req_waddr),
    .l2_req_wdata(l2_req_wdata),
    .l2_rsp_valid(l2_rsp_valid), .l2_rsp_kind(l2_rsp_kind),
    .l2_rsp_rdata(l2_rsp_rdata),
    .phase_start(phase_start), .phase_mask(phase_mask),
    .phase_done(phase_done), .regs_busy(regs_busy)
  );

  function automatic logic [DATA_W-1:0] fill_val(input logic [WADDR_W-1:0] wa);
    return 32'hC0DE_0000 | {18'b0, wa};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Shared-level model: acts just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      l2_rsp_valid = 1'b0;
      if (fill_pend) begin
        l2_rsp_valid = 1'b1;
        l2_rsp_kind  = 1'b0;
        l2_rsp_rdata = fill_val(fill_addr);
        fill_pend    = 1'b0;
      end else if (ack_pend > 0 && !hold_acks) begin
        l2_rsp_valid = 1'b1;
        l2_rsp_kind  = 1'b1;
        ack_pend--;
      end
      if (l2_req_valid && l2_req_ready) begin
        last_kind  = l2_req_kind;
        last_waddr = l2_req_waddr;
        last_wdata = l2_req_wdata;
        if (l2_req_kind) begin
          n_regs++;
          ack_pend++;
        end else begin
          n_reads++;
          fill_pend = 1'b1;
          fill_addr = l2_req_waddr;
        end
      end
    end
  end

  task automatic core_op(input bit wr, input logic [WADDR_W-1:0] wa,
                         input logic [DATA_W-1:0] wd, input logic [4:0] rg,
                         input int lag, output logic [DATA_W-1:0] rd);
    int guard;
    guard = 0;
    @(negedge clk);
    core_req_valid  = 1'b1;
    core_req_write  = wr;
    core_req_waddr  = wa;
    core_req_wdata  = wd;
    core_req_region = rg;
    while (!core_req_ready && guard < 1000) begin @(negedge clk); guard++; end
    @(negedge clk);
    core_req_valid = 1'b0;
    while (!core_rsp_valid && guard < 1000) begin @(negedge clk); guard++; end
    rd = core_rsp_rdata;
    for (int i = 0; i < lag; i++) begin
      @(negedge clk);
      chk(core_rsp_valid && core_rsp_rdata == rd, "R11 response held", core_rsp_rdata, rd);
    end
    core_rsp_ready = 1'b1;
    @(negedge clk);
    core_rsp_ready = 1'b0;
  endtask

  task automatic load_expect(input logic [WADDR_W-1:0] wa, input logic [4:0] rg,
                             input bit expect_read, input logic [DATA_W-1:0] exp,
                             input string req);
    logic [DATA_W-1:0] rd;
    int r0;
    r0 = n_reads;
    core_op(1'b0, wa, '0, rg, 0, rd);
    chk((n_reads - r0) == (expect_read ? 1 : 0), req, n_reads - r0, expect_read ? 1 : 0);
    chk(rd == exp, req, rd, exp);
  endtask

  task automatic store_expect(input logic [WADDR_W-1:0] wa, input logic [4:0] rg,
                              input logic [DATA_W-1:0] wd, input bit expect_reg,
                              input string req);
    logic [DATA_W-1:0] rd;
    int g0;
    g0 = n_regs;
    core_op(1'b1, wa, wd, rg, 0, rd);
    chk((n_regs - g0) == (expect_reg ? 1 : 0), req, n_regs - g0, expect_reg ? 1 : 0);
    if (expect_reg)
      chk(last_kind == 1'b1 && last_waddr == wa && last_wdata == wd, req, last_wdata, wd);
  endtask

  task automatic phase_run(input logic [31:0] m, output int cyc);
    @(negedge clk);
    phase_start = 1'b1;
    phase_mask  = m;
    @(negedge clk);
    phase_start = 1'b0;
    cyc = 1;
    while (!phase_done && cyc < 1000) begin @(negedge clk); cyc++; end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(core_req_ready && !core_rsp_valid && !l2_req_valid && !regs_busy && !phase_done,
        "R1 reset outputs",
        {27'b0, core_req_ready, core_rsp_valid, l2_req_valid, regs_busy, phase_done}, 32'h10);
  endtask

  task automatic t_load();
    load_expect(14'h010, 5'd3, 1'b1, fill_val(14'h010), "R2 load miss reads");
    chk(last_kind == 1'b0 && last_waddr == 14'h010, "R2 read request address",
        {17'b0, last_kind, last_waddr}, 32'h10);
    load_expect(14'h010, 5'd3, 1'b0, fill_val(14'h010), "R2 load hit no request");
  endtask

  task automatic t_store();
    hold_acks = 1'b1;
    store_expect(14'h011, 5'd3, 32'h1111_2222, 1'b1, "R3 store to Invalid registers");
    chk(regs_busy == 1'b1, "R4 busy while ack outstanding", regs_busy, 1);
    store_expect(14'h011, 5'd3, 32'h3333_4444, 1'b0, "R3 store to Registered no request");
    load_expect(14'h011, 5'd3, 1'b0, 32'h3333_4444, "R3 registered data returned");
    load_expect(14'h010, 5'd3, 1'b0, fill_val(14'h010), "R10 neighbour stays Valid");
    load_expect(14'h012, 5'd3, 1'b1, fill_val(14'h012), "R10 neighbour stays Invalid");
    store_expect(14'h010, 5'd3, 32'h5555_6666, 1'b1, "R3 store to Valid registers");
    hold_acks = 1'b0;
    repeat (6) @(negedge clk);
    chk(regs_busy == 1'b0, "R4 busy clears after acks", regs_busy, 0);
  endtask

  task automatic t_selfinv();
    int cyc;
    load_expect(14'h020, 5'd5, 1'b1, fill_val(14'h020), "R2 setup line2 w0");
    load_expect(14'h021, 5'd5, 1'b1, fill_val(14'h021), "R2 setup line2 w1");
    load_expect(14'h022, 5'd5, 1'b1, fill_val(14'h022), "R2 setup line2 w2");
    store_expect(14'h023, 5'd5, 32'hDEAD_0023, 1'b1, "R3 setup line2 w3");
    store_expect(14'h024, 5'd5, 32'hDEAD_0024, 1'b1, "R5 store to Invalid");
    load_expect(14'h030, 5'd6, 1'b1, fill_val(14'h030), "R2 setup line3 w0");
    repeat (4) @(negedge clk);
    phase_run(32'h1 << 5, cyc);
    chk(cyc == NUM_LINES + 2, "R9 scan length", cyc, NUM_LINES + 2);
    load_expect(14'h020, 5'd5, 1'b0, fill_val(14'h020), "R6 touched word survives");
    phase_run((32'h1 << 5) | (32'h1 << 3), cyc);
    chk(phase_done == 1'b1, "R9 done pulse seen", phase_done, 1);
    load_expect(14'h020, 5'd5, 1'b0, fill_val(14'h020), "R6 retouched word survives");
    load_expect(14'h021, 5'd5, 1'b1, fill_val(14'h021), "R8 touched bit cleared then purged");
    load_expect(14'h022, 5'd5, 1'b1, fill_val(14'h022), "R6 untouched masked purged");
    load_expect(14'h023, 5'd5, 1'b0, 32'hDEAD_0023, "R7 registered kept");
    load_expect(14'h024, 5'd5, 1'b0, 32'hDEAD_0024, "R5 R7 stored word kept");
    load_expect(14'h011, 5'd3, 1'b0, 32'h3333_4444, "R7 registered in line1 kept");
    load_expect(14'h012, 5'd3, 1'b1, fill_val(14'h012), "R6 line1 valid word purged");
    load_expect(14'h030, 5'd6, 1'b0, fill_val(14'h030), "R6 unmasked region kept");
  endtask

  task automatic t_wait();
    int cyc;
    bit bad;
    hold_acks = 1'b1;
    store_expect(14'h015, 5'd3, 32'h0000_0015, 1'b1, "R3 store before phase");
    @(negedge clk);
    phase_start = 1'b1;
    phase_mask  = 32'hFFFF_FFFF;
    @(negedge clk);
    phase_start = 1'b0;
    bad = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (phase_done || core_req_ready) bad = 1'b1;
    end
    chk(!bad, "R9 scan waits for acks, core held off", bad, 0);
    hold_acks = 1'b0;
    cyc = 0;
    while (!phase_done && cyc < 1000) begin @(negedge clk); cyc++; end
    chk(phase_done && !regs_busy, "R9 done after acks", {30'b0, phase_done, regs_busy}, 2);
    load_expect(14'h015, 5'd3, 1'b0, 32'h0000_0015, "R7 registered survives full mask");
  endtask

  task automatic t_realloc();
    load_expect(14'h000, 5'd1, 1'b1, fill_val(14'h000), "R12 first tag");
    load_expect(14'h040, 5'd1, 1'b1, fill_val(14'h040), "R12 conflicting tag");
    load_expect(14'h000, 5'd1, 1'b1, fill_val(14'h000), "R12 old line evicted");
    load_expect(14'h001, 5'd1, 1'b1, fill_val(14'h001), "R12 new line words Invalid");
  endtask

  task automatic t_hold();
    logic [DATA_W-1:0] rd;
    int r0;
    r0 = n_reads;
    l2_req_ready = 1'b0;
    fork
      core_op(1'b0, 14'h033, '0, 5'd6, 3, rd);
      begin
        int guard;
        bit bad;
        guard = 0;
        bad = 1'b0;
        while (!l2_req_valid && guard < 100) begin @(negedge clk); guard++; end
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          if (!(l2_req_valid && l2_req_kind == 1'b0 && l2_req_waddr == 14'h033)) bad = 1'b1;
        end
        chk(!bad, "R11 request held while not ready", {18'b0, l2_req_waddr}, 32'h33);
        l2_req_ready = 1'b1;
      end
    join
    chk(rd == fill_val(14'h033) && n_reads - r0 == 1, "R11 held load completes",
        rd, fill_val(14'h033));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements)");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_store();
    t_selfinv();
    t_wait();
    t_realloc();
    t_hold();
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule